// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into a serial frame on a single output line. Each frame has a low start bit, then 5 to 9 data bits sent least-significant first, then an optional even or odd parity bit, then one or two high stop bits. The frame layout is chosen per word from a small configuration set, and all 30 combinations are legal. The configuration is captured when the word is accepted, so software may change it while a frame is still going out.

Words enter through a ready/valid handshake. Bit slots advance on a shift enable. In asynchronous mode this enable is an externally generated baud tick. In synchronous mode it is the change edge of an external serial clock, which is sampled through a synchronizer, and a polarity input picks that edge. Ready rises during the last stop bit, so a word offered then starts on the very next slot with no idle gap. With no word pending, the line rests high.

Top module: `frame_tx`

## Requirements
- R1: After reset, `tx_out` is 1 and `in_ready` is 1.
- R2: A frame starts with one start slot at 0, followed by the data bits LSB first. The count is set by `cfg_len`: codes 0..4 select 5..9 bits, and codes 5..7 select 9 bits.
- R3: `cfg_par` selects parity: 0 = none, 1 = even, 2 = odd, 3 = none. When parity is enabled, one parity slot follows the last data bit. Even parity makes the ones count over the data bits plus parity even. Odd parity makes it odd.
- R4: The frame ends with one stop slot at 1, or two when `cfg_stop2` is 1.
- R5: Every combination of length code, parity mode and stop count produces the layout given in R2 to R4. The configuration and data in force at acceptance are used for the whole frame, even if the inputs change afterwards.
- R6: A word is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when no word is held and the line is idle or in its final stop slot. A word accepted during the final stop slot sends its start bit on the next shift enable.
- R7: On a shift enable with no frame remaining and no word held or offered, `tx_out` is 1.
- R8: With `sync_mode` = 0, `tx_out` changes only on the clock after a cycle with `baud_tick` = 1.
- R9: With `sync_mode` = 1, the shift enable is a rising `sclk` edge when `clk_pol` = 0, or a falling edge when `clk_pol` = 1. `sclk` is sampled through `SYNC_STAGES` (default 2) flops. `tx_out` updates on the clock edge `SYNC_STAGES` edges after the edge that first samples the new `sclk` level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can take a word |
| in_data | input | 9 | Character; only the low bits selected by cfg_len are sent |
| cfg_len | input | 3 | Data length code (0..4 give 5..9 bits; 5..7 give 9 bits) |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| sync_mode | input | 1 | 1 selects serial-clock timing, 0 selects baud tick |
| clk_pol | input | 1 | Change edge in synchronous mode: 0 rising, 1 falling |
| baud_tick | input | 1 | One-cycle pulse per bit slot in asynchronous mode |
| sclk | input | 1 | External serial clock used in synchronous mode |
| tx_out | output | 1 | Serial data line |

## Verification
All 30 format combinations are sent with data words whose ones counts differ. This separates the length, parity-sense and stop-count decisions from one another. The configuration inputs are scrambled right after each acceptance, which shows whether the block latches the format or reads it live. Words are offered both while the line is idle and during the last stop bit. The first case exercises the holding path and the second the direct gapless start. Synchronous runs with both polarities show whether the block moves on the selected edge rather than the opposite one. A slower baud rate and idle stretches show that the line holds still between enables.

// File: rtl/frame_tx_pkg.sv
// Package: shared sizes, the parity encoding and the frame record for the
// serial frame transmitter. Assumes the data length never exceeds 9 bits.
package frame_tx_pkg;
    localparam int DATA_W  = 9;                    // widest character
    localparam int MIN_BITS = 5;                   // narrowest character
    localparam int FRAME_W = 1 + DATA_W + 1 + 2;   // start + data + parity + 2 stop
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // slot order, bit 0 goes out first
        logic [CNT_W-1:0]   len;   // number of slots in the frame
    } frame_t;

    // Map a length code onto a data bit count; codes above 4 mean 9 bits.
    function automatic int unsigned data_bits(input logic [2:0] code);
        if (code > 3'd4) return DATA_W;
        return MIN_BITS + int'(code);
    endfunction
endpackage

// File: rtl/frame_tx_step.sv
// Module: shift-enable source. In asynchronous mode it passes the baud tick.
// In synchronous mode it synchronizes the serial clock and flags the edge
// chosen by the polarity bit. Assumes SYNC_STAGES >= 1 and that sclk is
// much slower than clk.
module frame_tx_step #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic clk_pol,
    input  logic baud_tick,
    input  logic sclk,
    output logic step_en
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;

    // Synchronizer chain for the external serial clock.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sclk;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sclk};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    // Previous synchronized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Pick the change edge for synchronous mode, or the tick otherwise.
    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        if (sync_mode) step_en = clk_pol ? fall : rise;
        else           step_en = baud_tick;
    end
endmodule

// File: rtl/frame_tx_build.sv
// Module: assembles one frame as a slot vector from a character and a
// format. Purely combinational. Slots past the frame length read as 1.
module frame_tx_build
    import frame_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        len_code,
    input  logic [1:0]        par_code,
    input  logic              stop2,
    output frame_t            frame
);
    int unsigned nbits;
    logic        par_on;
    logic        ones_odd;
    logic        par_bit;

    // Work out data length, parity enable and the parity value.
    always_comb begin
        nbits    = data_bits(len_code);
        par_on   = (par_code == PAR_EVEN) || (par_code == PAR_ODD);
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) ones_odd = ones_odd ^ data[i];
        end
        par_bit = (par_code == PAR_ODD) ? ~ones_odd : ones_odd;
    end

    // Place start, data and parity slots. Stop slots are the 1s left over.
    always_comb begin
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int p = 1; p < FRAME_W; p++) begin
            if (p <= int'(nbits))                    frame.bits[p] = data[p-1];
            else if (par_on && p == int'(nbits) + 1) frame.bits[p] = par_bit;
        end
        frame.len = CNT_W'(1 + nbits + (par_on ? 1 : 0) + (stop2 ? 2 : 1));
    end
endmodule

// File: rtl/frame_tx_serial.sv
// Module: one-word holding slot plus a slot shifter that drives the line.
// Assumes the step input is a single-cycle enable. The frame passed in is
// already fully assembled, so it holds the format in force at acceptance.
module frame_tx_serial
    import frame_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   in_valid,
    input  frame_t in_frame,
    output logic   in_ready,
    output logic   tx_out
);
    logic               tx_q, tx_d;
    logic [FRAME_W-1:0] shift_q, shift_d;
    logic [CNT_W-1:0]   left_q, left_d;
    frame_t             hold_q, hold_d;
    logic               hold_v_q, hold_v_d;
    logic               accept;
    logic               at_end;

    assign at_end   = (left_q == '0);
    assign in_ready = ~hold_v_q & at_end;
    assign accept   = in_valid & in_ready;
    assign tx_out   = tx_q;

    // Next-state logic for the line, the shifter and the holding slot.
    always_comb begin
        tx_d     = tx_q;
        shift_d  = shift_q;
        left_d   = left_q;
        hold_d   = hold_q;
        hold_v_d = hold_v_q;
        if (step_en) begin
            if (!at_end) begin
                tx_d    = shift_q[0];
                shift_d = {1'b1, shift_q[FRAME_W-1:1]};
                left_d  = left_q - 1'b1;
            end else if (hold_v_q) begin
                tx_d     = hold_q.bits[0];
                shift_d  = {1'b1, hold_q.bits[FRAME_W-1:1]};
                left_d   = hold_q.len - 1'b1;
                hold_v_d = 1'b0;
            end else if (accept) begin
                tx_d    = in_frame.bits[0];
                shift_d = {1'b1, in_frame.bits[FRAME_W-1:1]};
                left_d  = in_frame.len - 1'b1;
            end else begin
                tx_d = 1'b1;
            end
        end
        if (accept && !step_en) begin
            hold_d   = in_frame;
            hold_v_d = 1'b1;
        end
    end

    // State registers, with the line resting high out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= 1'b1;
            shift_q  <= '1;
            left_q   <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
        end else begin
            tx_q     <= tx_d;
            shift_q  <= shift_d;
            left_q   <= left_d;
            hold_q   <= hold_d;
            hold_v_q <= hold_v_d;
        end
    end
endmodule

// File: rtl/frame_tx.sv
// Module: top of the configurable serial frame transmitter. It ties the
// shift-enable source, the frame assembler and the serializer together.
// Assumes baud_tick pulses last one clock and that sclk is slow compared
// with clk.
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [2:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              sync_mode,
    input  logic              clk_pol,
    input  logic              baud_tick,
    input  logic              sclk,
    output logic              tx_out
);
    logic   step_en;
    frame_t new_frame;

    frame_tx_step #(.SYNC_STAGES(SYNC_STAGES)) i_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_mode(sync_mode),
        .clk_pol  (clk_pol),
        .baud_tick(baud_tick),
        .sclk     (sclk),
        .step_en  (step_en)
    );

    frame_tx_build i_build (
        .data    (in_data),
        .len_code(cfg_len),
        .par_code(cfg_par),
        .stop2   (cfg_stop2),
        .frame   (new_frame)
    );

    frame_tx_serial i_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .in_valid(in_valid),
        .in_frame(new_frame),
        .in_ready(in_ready),
        .tx_out  (tx_out)
    );
endmodule

// File: rtl/frame_tx_chk.sv
// Module: protocol checker for frame_tx, attached with bind. It observes
// the ports and the internal shift enable only.
module frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic sync_mode,
    input logic baud_tick,
    input logic step_en,
    input logic tx_out
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_out && in_ready));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && in_valid && in_ready) |=> !tx_out);

    // R6
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !step_en) |=> !in_ready);

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && in_ready && !in_valid) |=> tx_out);

    // R8
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !baud_tick) |=> $stable(tx_out));

    // R9
    step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(tx_out));
endmodule

bind frame_tx frame_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sync_mode(sync_mode),
    .baud_tick(baud_tick),
    .step_en  (step_en),
    .tx_out   (tx_out)
);

// File: tb/test_frame_tx.sv
// Bench: behavioural queue model of the line, compared on every clock.
module test_frame_tx;
    typedef bit bitq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic [2:0] cfg_len = '0;
    logic [1:0] cfg_par = '0;
    logic       cfg_stop2 = 1'b0;
    logic       sync_mode = 1'b0;
    logic       clk_pol = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       tx_out;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    int    baud_div = 3;
    bit    baud_en = 0;
    int    baud_cnt = 0;
    bit    sclk_en = 0;
    int    sclk_cnt = 0;

    bitq_t rem;
    bitq_t hold;
    bit    hold_v = 0;
    bit    m_tx = 1;
    bit    h1 = 0, h2 = 0, h3 = 0;

    always #4 clk = ~clk;   // 125 MHz

    frame_tx i_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .sync_mode(sync_mode), .clk_pol(clk_pol),
        .baud_tick(baud_tick), .sclk(sclk), .tx_out(tx_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Frame from the requirements: start, data LSB first, parity, stops.
    function automatic bitq_t mk(input logic [8:0] d, input logic [2:0] lc,
                                 input logic [1:0] pc, input logic s2);
        bitq_t q;
        int n = (lc > 4) ? 9 : lc + 5;
        int ones = 0;
        q.push_back(0);
        for (int i = 0; i < n; i++) begin
            q.push_back(d[i]);
            ones += d[i];
        end
        if (pc == 1) q.push_back(ones % 2);
        if (pc == 2) q.push_back(1 - ones % 2);
        q.push_back(1);
        if (s2) q.push_back(1);
        return q;
    endfunction

    // Reference model step, then compare once outputs have settled.
    always @(posedge clk) begin
        bit step, rdy, acc, used;
        if (!rst_n) begin
            rem.delete(); hold.delete(); hold_v = 0; m_tx = 1;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            step = sync_mode ? (clk_pol ? (!h2 && h3) : (h2 && !h3)) : baud_tick;
            h3 = h2; h2 = h1; h1 = sclk;
            rdy = !hold_v && rem.size() == 0;
            acc = in_valid && rdy;
            used = 0;
            if (step) begin
                if (rem.size() != 0) m_tx = rem.pop_front();
                else if (hold_v) begin
                    rem = hold; m_tx = rem.pop_front(); hold_v = 0;
                end else if (acc) begin
                    rem = mk(in_data, cfg_len, cfg_par, cfg_stop2);
                    m_tx = rem.pop_front(); used = 1;
                end else m_tx = 1;
            end
            if (acc && !used) begin
                hold = mk(in_data, cfg_len, cfg_par, cfg_stop2); hold_v = 1;
            end
            #1;
            chk(cur_req, tx_out, m_tx);
            chk("R6", in_ready, (!hold_v && rem.size() == 0));
        end
    end

    // Baud tick and serial clock generators.
    always @(negedge clk) begin
        baud_tick = 0;
        if (baud_en) begin
            baud_cnt++;
            if (baud_cnt >= baud_div) begin baud_cnt = 0; baud_tick = 1; end
        end
        if (sclk_en) begin
            sclk_cnt++;
            if (sclk_cnt >= 4) begin sclk_cnt = 0; sclk = ~sclk; end
        end
    end

    // Offer one word and scramble the format after acceptance.
    task automatic send(input logic [8:0] d, input logic [2:0] lc,
                        input logic [1:0] pc, input logic s2);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_data = d; cfg_len = lc; cfg_par = pc; cfg_stop2 = s2;
        @(negedge clk);
        in_valid = 0; in_data = ~d; cfg_len = lc + 3'd2; cfg_par = pc + 2'd1;
        cfg_stop2 = ~s2;
    endtask

    task automatic drain();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", tx_out, 1);
        chk("R1", in_ready, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1", tx_out, 1);
        chk("R1", in_ready, 1);

        baud_en = 1;
        cur_req = "R2";
        send(9'h0B5, 3'd0, 2'd0, 1'b0);
        send(9'h1A3, 3'd4, 2'd0, 1'b0);
        send(9'h155, 3'd6, 2'd0, 1'b0);
        send(9'h1FF, 3'd7, 2'd0, 1'b0);
        drain();
        cur_req = "R3";
        send(9'h00F, 3'd3, 2'd1, 1'b0);
        send(9'h007, 3'd3, 2'd1, 1'b0);
        send(9'h00F, 3'd3, 2'd2, 1'b0);
        send(9'h107, 3'd4, 2'd2, 1'b0);
        send(9'h0AA, 3'd3, 2'd3, 1'b0);
        drain();
        cur_req = "R4";
        send(9'h1C3, 3'd2, 2'd0, 1'b1);
        send(9'h03C, 3'd2, 2'd1, 1'b1);
        drain();
        cur_req = "R5";
        for (int l = 0; l < 5; l++)
            for (int p = 0; p < 3; p++)
                for (int s = 0; s < 2; s++)
                    send(9'((l * 97 + p * 41 + s * 13 + 5) & 9'h1FF),
                         3'(l), 2'(p), 1'(s));
        drain();
        cur_req = "R7";
        repeat (30) @(negedge clk);
        chk("R7", tx_out, 1);
        cur_req = "R8";
        baud_div = 5;
        send(9'h0C6, 3'd3, 2'd2, 1'b1);
        send(9'h139, 3'd4, 2'd1, 1'b0);
        drain();
        baud_en = 0;

        cur_req = "R9";
        repeat (10) @(negedge clk);
        sync_mode = 1; clk_pol = 0; sclk_en = 1;
        repeat (20) @(negedge clk);
        send(9'h0A5, 3'd3, 2'd1, 1'b0);
        send(9'h14B, 3'd4, 2'd2, 1'b1);
        drain();
        clk_pol = 1;
        repeat (20) @(negedge clk);
        send(9'h05A, 3'd3, 2'd2, 1'b0);
        send(9'h0E1, 3'd1, 2'd0, 1'b1);
        drain();
        sclk_en = 0;
        chk("R9", tx_out, 1);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule